// File: doc/BRIEF.md
# Non-Shared Region Filter Table

This block is a small set-associative filter that remembers aligned, power-of-two sized memory regions that no other node in a snooping system currently caches. Before a node issues a request, it looks the request address up here. A hit means no remote node holds any block of that region, so the request can go out without a snoop broadcast.

Entries are created only when a broadcast comes back with a global region miss, reported on the fill port. Entries are removed when a request from another node arrives on the snoop port for any address inside a recorded region. This makes the table a filter that corrects itself. A lost entry only costs a broadcast that was not needed. A region that has become shared is never reported as a hit.

The address is split into three fields. The low `REGION_LG` bits are the offset inside a region. The next `log2(SETS)` bits pick the set. The remaining high bits form the stored tag.

Top module: `region_filter_table`

## Requirements
- R1: After reset no region is recorded, `lk_vld_o` and `lk_hit_o` are low, and every lookup misses until a fill is accepted.
- R2: `lk_vld_o` is high exactly in the cycle after a cycle with `lk_req_i` high, and `lk_hit_o` is never high while `lk_vld_o` is low.
- R3: A lookup hits when its region (address bits `[ADDR_W-1:REGION_LG]`) is recorded. Every offset inside the region gives the same result. The set is chosen by address bits `[REGION_LG+log2(SETS)-1:REGION_LG]`.
- R4: A fill records its region, so a lookup to that region in any later cycle hits until the entry is removed. A lookup in the same cycle as the fill sees the table as it was before the fill.
- R5: A snoop to any address in a recorded region removes that region, so lookups in later cycles miss.
- R6: When a fill and a snoop name the same region in the same cycle, the snoop wins and the region is not recorded.
- R7: A fill for a region that is already recorded leaves the set unchanged, and no region is ever held in two ways.
- R8: A fill into a set that has an empty way uses the lowest-numbered empty way and evicts nothing.
- R9: A fill into a full set replaces the way named by that set's round-robin pointer. The pointer starts at way 0 and advances by one, wrapping, only on such replacements. Each set has its own pointer.
- R10: A lookup in the same cycle as a snoop to the same region reports a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lk_req_i | input | 1 | Local lookup strobe |
| lk_addr_i | input | ADDR_W | Local request address |
| lk_vld_o | output | 1 | Lookup result valid, one cycle after the strobe |
| lk_hit_o | output | 1 | Region known non-shared |
| fill_i | input | 1 | Global region miss: record the region |
| fill_addr_i | input | ADDR_W | Address of the request that missed globally |
| snp_i | input | 1 | Remote snoop strobe |
| snp_addr_i | input | ADDR_W | Address requested by a remote node |

## Verification
Lookup results are due exactly one clock after the strobe. Fills and snoops change what lookups return starting with a lookup issued in the following cycle. The bench drives every input on the falling edge. It checks the registered result on the next falling edge, against a prediction made when the strobe was driven. That prediction comes from a reference table held as it stood before the same-cycle fill and snoop were applied, so same-cycle interactions are scored against the pre-update state. Directed sequences fill single sets past capacity to expose which way is evicted. Random traffic over a narrow pool of regions forces frequent conflicts, duplicate fills and fill/snoop collisions.

// File: rtl/nsr_pkg.sv
package nsr_pkg;
  localparam int unsigned DEF_ADDR_W    = 32;
  localparam int unsigned DEF_REGION_LG = 14;  // 16 KB regions
  localparam int unsigned DEF_SETS      = 16;
  localparam int unsigned DEF_WAYS      = 4;
endpackage

// File: rtl/nsr_addr_split.sv
module nsr_addr_split #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned REGION_LG = 14,
  parameter int unsigned IDX_W     = 4,
  localparam int unsigned TAG_W    = ADDR_W - REGION_LG - IDX_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic [TAG_W-1:0]  tag_o
);
  assign idx_o = addr_i[REGION_LG +: IDX_W];
  assign tag_o = addr_i[ADDR_W-1 -: TAG_W];
endmodule

// File: rtl/nsr_victim.sv
module nsr_victim #(
  parameter int unsigned WAYS = 4,
  localparam int unsigned WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic [WAYS-1:0]  valid_i,
  input  logic [WAY_W-1:0] ptr_i,
  output logic [WAY_W-1:0] way_o,
  output logic             full_o
);
  always_comb begin
    full_o = &valid_i;
    way_o  = ptr_i;
    // lowest empty way wins
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (!valid_i[i]) way_o = WAY_W'(i);
    end
  end
endmodule

// File: rtl/nsr_set.sv
module nsr_set #(
  parameter int unsigned WAYS  = 4,
  parameter int unsigned TAG_W = 14,
  localparam int unsigned WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [TAG_W-1:0] lk_tag_i,
  output logic [WAYS-1:0]  lk_match_o,
  input  logic             snp_en_i,
  input  logic [TAG_W-1:0] snp_tag_i,
  input  logic             fill_en_i,
  input  logic [TAG_W-1:0] fill_tag_i
);
  logic [WAYS-1:0]  valid_q, valid_d;
  logic [TAG_W-1:0] tag_q [WAYS];
  logic [WAY_W-1:0] ptr_q;
  logic [WAYS-1:0]  snp_hit, fill_hit;
  logic [WAY_W-1:0] vic_way;
  logic             set_full;
  logic             fill_new;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign lk_match_o[w] = valid_q[w] && (tag_q[w] == lk_tag_i);
    assign snp_hit[w]    = valid_q[w] && (tag_q[w] == snp_tag_i);
    assign fill_hit[w]   = valid_q[w] && (tag_q[w] == fill_tag_i);
  end

  nsr_victim #(.WAYS(WAYS)) u_victim (
    .valid_i (valid_q),
    .ptr_i   (ptr_q),
    .way_o   (vic_way),
    .full_o  (set_full)
  );

  assign fill_new = fill_en_i && !(|fill_hit);

  always_comb begin
    valid_d = valid_q;
    if (snp_en_i) valid_d = valid_d & ~snp_hit;
    if (fill_new) valid_d[vic_way] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      ptr_q   <= '0;
      for (int w = 0; w < WAYS; w++) tag_q[w] <= '0;
    end else begin
      valid_q <= valid_d;
      if (fill_new) begin
        tag_q[vic_way] <= fill_tag_i;
        if (set_full) ptr_q <= (ptr_q == WAY_W'(WAYS - 1)) ? '0 : ptr_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/region_filter_table.sv
module region_filter_table #(
  parameter int unsigned ADDR_W    = nsr_pkg::DEF_ADDR_W,
  parameter int unsigned REGION_LG = nsr_pkg::DEF_REGION_LG,
  parameter int unsigned SETS      = nsr_pkg::DEF_SETS,
  parameter int unsigned WAYS      = nsr_pkg::DEF_WAYS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lk_req_i,
  input  logic [ADDR_W-1:0] lk_addr_i,
  output logic              lk_vld_o,
  output logic              lk_hit_o,
  input  logic              fill_i,
  input  logic [ADDR_W-1:0] fill_addr_i,
  input  logic              snp_i,
  input  logic [ADDR_W-1:0] snp_addr_i
);
  localparam int unsigned IDX_W = (SETS > 1) ? $clog2(SETS) : 1;
  localparam int unsigned TAG_W = ADDR_W - REGION_LG - IDX_W;

  logic [IDX_W-1:0] lk_idx, fill_idx, snp_idx;
  logic [TAG_W-1:0] lk_tag, fill_tag, snp_tag;
  logic [WAYS-1:0]  set_match [SETS];
  logic [WAYS-1:0]  lk_match;
  logic             fill_go, snp_on_lk, hit_d;

  nsr_addr_split #(.ADDR_W(ADDR_W), .REGION_LG(REGION_LG), .IDX_W(IDX_W)) u_lk_split (
    .addr_i(lk_addr_i), .idx_o(lk_idx), .tag_o(lk_tag));
  nsr_addr_split #(.ADDR_W(ADDR_W), .REGION_LG(REGION_LG), .IDX_W(IDX_W)) u_fill_split (
    .addr_i(fill_addr_i), .idx_o(fill_idx), .tag_o(fill_tag));
  nsr_addr_split #(.ADDR_W(ADDR_W), .REGION_LG(REGION_LG), .IDX_W(IDX_W)) u_snp_split (
    .addr_i(snp_addr_i), .idx_o(snp_idx), .tag_o(snp_tag));

  // snoop to the same region kills the fill
  assign fill_go = fill_i && !(snp_i && snp_idx == fill_idx && snp_tag == fill_tag);

  for (genvar s = 0; s < SETS; s++) begin : g_set
    nsr_set #(.WAYS(WAYS), .TAG_W(TAG_W)) u_set (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .lk_tag_i   (lk_tag),
      .lk_match_o (set_match[s]),
      .snp_en_i   (snp_i && snp_idx == IDX_W'(s)),
      .snp_tag_i  (snp_tag),
      .fill_en_i  (fill_go && fill_idx == IDX_W'(s)),
      .fill_tag_i (fill_tag)
    );
  end

  assign lk_match  = set_match[lk_idx];
  assign snp_on_lk = snp_i && snp_idx == lk_idx && snp_tag == lk_tag;
  assign hit_d     = lk_req_i && (|lk_match) && !snp_on_lk;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lk_vld_o <= 1'b0;
      lk_hit_o <= 1'b0;
    end else begin
      lk_vld_o <= lk_req_i;
      lk_hit_o <= hit_d;
    end
  end
endmodule

// File: rtl/nsr_chk.sv
module nsr_chk #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned REGION_LG = 14,
  parameter int unsigned WAYS      = 4,
  localparam int unsigned RG_W     = ADDR_W - REGION_LG
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              lk_req_i,
  input logic [ADDR_W-1:0] lk_addr_i,
  input logic              lk_vld_o,
  input logic              lk_hit_o,
  input logic              fill_i,
  input logic [ADDR_W-1:0] fill_addr_i,
  input logic              snp_i,
  input logic [ADDR_W-1:0] snp_addr_i,
  input logic [WAYS-1:0]   lk_match_i
);
  logic [RG_W-1:0] lk_rg, fill_rg, snp_rg, fill_rg_q, snp_rg_q;
  logic armed_q, fill_ok_q, snp_q;

  assign lk_rg   = lk_addr_i[ADDR_W-1:REGION_LG];
  assign fill_rg = fill_addr_i[ADDR_W-1:REGION_LG];
  assign snp_rg  = snp_addr_i[ADDR_W-1:REGION_LG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q   <= 1'b0;
      fill_ok_q <= 1'b0;
      snp_q     <= 1'b0;
      fill_rg_q <= '0;
      snp_rg_q  <= '0;
    end else begin
      armed_q   <= 1'b1;
      fill_ok_q <= fill_i && !(snp_i && snp_rg == fill_rg);
      snp_q     <= snp_i;
      fill_rg_q <= fill_rg;
      snp_rg_q  <= snp_rg;
    end
  end

  assert_vld_follows_req_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |-> (lk_vld_o == $past(lk_req_i)));

  assert_hit_implies_vld_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_hit_o |-> lk_vld_o);

  assert_fill_then_hit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_ok_q && lk_req_i && lk_rg == fill_rg_q && !(snp_i && snp_rg == lk_rg)) |=> lk_hit_o);

  // covers R6 too: a blocked fill leaves nothing to hit
  assert_snoop_clears_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snp_q && lk_req_i && lk_rg == snp_rg_q) |=> !lk_hit_o);

  assert_no_dup_way_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(lk_match_i));

  assert_snoop_masks_lookup_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_req_i && snp_i && snp_rg == lk_rg) |=> !lk_hit_o);
endmodule

bind region_filter_table nsr_chk #(
  .ADDR_W(ADDR_W), .REGION_LG(REGION_LG), .WAYS(WAYS)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .lk_req_i    (lk_req_i),
  .lk_addr_i   (lk_addr_i),
  .lk_vld_o    (lk_vld_o),
  .lk_hit_o    (lk_hit_o),
  .fill_i      (fill_i),
  .fill_addr_i (fill_addr_i),
  .snp_i       (snp_i),
  .snp_addr_i  (snp_addr_i),
  .lk_match_i  (lk_match)
);

// File: tb/sim_region_filter_table.sv
module sim_region_filter_table;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32, RLG = 14, NS = 16, NW = 4;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic lk_req = 1'b0, fill = 1'b0, snp = 1'b0;
  logic [AW-1:0] lk_addr = '0, fill_addr = '0, snp_addr = '0;
  logic lk_vld, lk_hit;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // reference table
  bit        mv [NS][NW];
  bit [13:0] mt [NS][NW];
  int        mptr [NS];
  bit        pend = 0, exp_vld = 0, exp_hit = 0;
  string     pend_req = "";

  always #(CLK_PERIOD/2) clk = ~clk;

  region_filter_table #(.ADDR_W(AW), .REGION_LG(RLG), .SETS(NS), .WAYS(NW)) u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .lk_req_i(lk_req), .lk_addr_i(lk_addr), .lk_vld_o(lk_vld), .lk_hit_o(lk_hit),
    .fill_i(fill), .fill_addr_i(fill_addr), .snp_i(snp), .snp_addr_i(snp_addr));

  function automatic logic [AW-1:0] ra(int tag, int idx, int off);
    return {tag[13:0], idx[3:0], off[13:0]};
  endfunction

  function automatic bit m_has(logic [AW-1:0] a);
    int s = int'(a[17:14]);
    for (int w = 0; w < NW; w++) if (mv[s][w] && mt[s][w] == a[31:18]) return 1;
    return 0;
  endfunction

  task automatic check(string r, logic act, logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0b expected %0b at %0t", r, act, exp, $time);
    end
  endtask

  task automatic m_update(bit f, logic [AW-1:0] fa, bit s, logic [AW-1:0] sa);
    bit fok, full;
    int fs, vw;
    fs  = int'(fa[17:14]);
    fok = f && !(s && fa[31:14] == sa[31:14]) && !m_has(fa);
    vw = -1; full = 1;
    if (fok) begin
      for (int w = NW - 1; w >= 0; w--) if (!mv[fs][w]) begin vw = w; full = 0; end
      if (full) begin vw = mptr[fs]; mptr[fs] = (mptr[fs] + 1) % NW; end
    end
    if (s) for (int w = 0; w < NW; w++)
      if (mv[int'(sa[17:14])][w] && mt[int'(sa[17:14])][w] == sa[31:18]) mv[int'(sa[17:14])][w] = 0;
    if (fok) begin mv[fs][vw] = 1; mt[fs][vw] = fa[31:18]; end
  endtask

  // one cycle: settle previous result, drive, predict
  task automatic step(bit l, logic [AW-1:0] la, bit f, logic [AW-1:0] fa,
                      bit s, logic [AW-1:0] sa, string r);
    @(negedge clk);
    if (pend) begin
      check({pend_req, "/R2 vld"}, lk_vld, exp_vld);
      check(pend_req, lk_hit, exp_hit);
    end
    lk_req = l; lk_addr = la; fill = f; fill_addr = fa; snp = s; snp_addr = sa;
    exp_vld = l;
    exp_hit = l && m_has(la) && !(s && sa[31:14] == la[31:14]);
    pend = 1; pend_req = r;
    m_update(f, fa, s, sa);
  endtask

  task automatic look(logic [AW-1:0] a, string r);
    step(1, a, 0, '0, 0, '0, r);
  endtask
  task automatic put(logic [AW-1:0] a);
    step(0, '0, 1, a, 0, '0, "R4");
  endtask
  task automatic kill(logic [AW-1:0] a);
    step(0, '0, 0, '0, 1, a, "R5");
  endtask

  initial begin
    for (int s = 0; s < NS; s++) begin
      mptr[s] = 0;
      for (int w = 0; w < NW; w++) begin mv[s][w] = 0; mt[s][w] = '0; end
    end
    void'($urandom(1234));
    repeat (3) @(negedge clk);
    check("R1 vld", lk_vld, 1'b0);
    check("R1 hit", lk_hit, 1'b0);
    rst_ni = 1'b1;
    look(ra(5, 3, 0), "R1");
    // fill, same-cycle lookup sees old state, later lookup hits at other offset
    step(1, ra(5, 3, 7), 1, ra(5, 3, 100), 0, '0, "R4");
    look(ra(5, 3, 16383), "R3");
    look(ra(5, 4, 0), "R3");        // other set
    look(ra(6, 3, 0), "R3");        // other tag
    // same-cycle lookup vs snoop
    step(1, ra(5, 3, 1), 0, '0, 1, ra(5, 3, 9), "R10");
    look(ra(5, 3, 2), "R5");
    // fill and snoop same region
    step(0, '0, 1, ra(7, 3, 0), 1, ra(7, 3, 55), "R6");
    look(ra(7, 3, 0), "R6");
    // duplicate fill, then fill set 2 past capacity
    put(ra(10, 2, 0)); put(ra(10, 2, 4)); put(ra(11, 2, 0)); put(ra(12, 2, 0)); put(ra(13, 2, 0));
    look(ra(10, 2, 0), "R7"); look(ra(13, 2, 0), "R7");
    put(ra(14, 2, 0));              // evicts way0 (tag 10)
    look(ra(10, 2, 0), "R9"); look(ra(11, 2, 0), "R9"); look(ra(14, 2, 0), "R9");
    put(ra(15, 2, 0));              // evicts way1 (tag 11)
    look(ra(11, 2, 0), "R9"); look(ra(12, 2, 0), "R9");
    // empty way reused first
    kill(ra(13, 2, 0));
    put(ra(16, 2, 0));
    look(ra(14, 2, 0), "R8"); look(ra(15, 2, 0), "R8"); look(ra(12, 2, 0), "R8"); look(ra(16, 2, 0), "R8");
    // per-set pointer: set 9 starts at way 0
    for (int t = 20; t < 25; t++) put(ra(t, 9, 0));
    look(ra(20, 9, 0), "R9"); look(ra(21, 9, 0), "R9");
    // random traffic over a narrow pool
    for (int i = 0; i < 4000; i++) begin
      bit l, f, s;
      logic [AW-1:0] la, fa, sa;
      l = ($urandom % 4) != 0; f = ($urandom % 3) == 0; s = ($urandom % 4) == 0;
      la = ra($urandom % 6, $urandom % 3, $urandom % 16384);
      fa = ra($urandom % 6, $urandom % 3, $urandom % 16384);
      sa = ($urandom % 3 == 0) ? fa : ra($urandom % 6, $urandom % 3, $urandom % 16384);
      step(l, la, f, fa, s, sa, "R3/R4/R5/R9 random");
    end
    step(0, '0, 0, '0, 0, '0, "R2 idle");
    step(0, '0, 0, '0, 0, '0, "R2 idle");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule